// File: doc/BRIEF.md
# Radix-4 Booth Digit Recoder and Partial-Product Selector

This cell turns one overlapping three-bit slice of a multiplier into one signed partial product of a radix-4 multiplier. A slice is read as a signed digit in {-2, -1, 0, +1, +2}. The digit is decoded into three control lines:

- `dig_zero` clears the operand.
- `dig_shift` picks the operand doubled instead of the plain operand.
- `dig_neg` inverts every bit of the result.

All selection is gating and multiplexing, so the cell's delay does not grow with the operand width. There is no carry chain anywhere in the cell.

A negated partial product is left in one's-complement form. The missing +1 is exported on `pp_corr`. A later summing stage must add it at the least significant weight of that partial product.

The output is one bit wider than the multiplicand, so that twice the multiplicand fits in signed form. The cell has no state, so there are no states or transitions. A multiplier array places one instance per digit position. Summation and sign-extension handling are left to the array.

Top module: `booth_recode_cell`

## Requirements
- R1: Slices 3'b000 and 3'b111 give digit 0. The output `pp` is all zeros and `pp_corr` is 0.
- R2: Slices 3'b001 and 3'b010 give digit +1. `pp` equals the multiplicand sign-extended to WIDTH+1 bits, and `pp_corr` is 0.
- R3: Slice 3'b011 gives digit +2. `pp` equals the sign-extended multiplicand shifted left by one place with a zero fill, and `pp_corr` is 0.
- R4: Slice 3'b100 gives digit -2. `pp` is the bitwise inverse of the value in R3, and `pp_corr` is 1.
- R5: Slices 3'b101 and 3'b110 give digit -1. `pp` is the bitwise inverse of the value in R2, and `pp_corr` is 1.
- R6: Let `pp` be read as a signed WIDTH+1-bit value. Then `pp` plus `pp_corr`, computed in wide integer arithmetic, equals the digit times the signed multiplicand for every slice and every multiplicand, the most negative one included. `pp_corr` always equals `dig_neg`.
- R7: The control lines follow the slice. `dig_zero` is high only for 000 and 111. `dig_shift` is high only for 011 and 100. `dig_neg` is high only for 100, 101 and 110.
- R8: The cell is purely combinational. Its outputs settle to the new value within the same clock cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp | input | 3 | Overlapping multiplier slice; bit 0 is the lower neighbour's top bit |
| mcand | input | WIDTH | Signed multiplicand |
| pp | output | WIDTH+1 | Selected partial product, one's complement when negated |
| pp_corr | output | 1 | +1 still owed at this partial product's LSB weight |
| dig_zero | output | 1 | Decoded zero control |
| dig_shift | output | 1 | Decoded double control |
| dig_neg | output | 1 | Decoded negate control |

## Verification
Two functions can act in the same evaluation: the doubling multiplexer and the inverter. This happens only for slice 100.

A collision between the zeroing gate and the inverter can only show up as a skewed result on slice 111. The bench provokes both cases by sweeping every slice against every multiplicand value, the most negative one included. It judges each result against an expected value computed arithmetically from the digit. For the -2 and most-negative case, the bench requires the inverted 9-bit pattern plus the correction bit to reach +256, one step beyond the signed range of `pp`.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef struct packed {
        logic zero;
        logic shift;
        logic neg;
    } booth_ctrl_t;
endpackage

// File: rtl/booth_digit_decode.sv
module booth_digit_decode
    import booth_pkg::*;
(
    input  logic [2:0]  grp,
    output booth_ctrl_t ctrl
);
    always_comb begin
        unique case (grp)
            3'b000:  ctrl = '{zero: 1'b1, shift: 1'b0, neg: 1'b0};
            3'b001:  ctrl = '{zero: 1'b0, shift: 1'b0, neg: 1'b0};
            3'b010:  ctrl = '{zero: 1'b0, shift: 1'b0, neg: 1'b0};
            3'b011:  ctrl = '{zero: 1'b0, shift: 1'b1, neg: 1'b0};
            3'b100:  ctrl = '{zero: 1'b0, shift: 1'b1, neg: 1'b1};
            3'b101:  ctrl = '{zero: 1'b0, shift: 1'b0, neg: 1'b1};
            3'b110:  ctrl = '{zero: 1'b0, shift: 1'b0, neg: 1'b1};
            default: ctrl = '{zero: 1'b1, shift: 1'b0, neg: 1'b0};
        endcase
    end

    // R7: a zero digit never asks for doubling or negation
    always_comb begin
        a_r7_zero_alone: assert (!(ctrl.zero && (ctrl.shift || ctrl.neg)));
    end
endmodule

// File: rtl/booth_pp_select.sv
module booth_pp_select
    import booth_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int PW = WIDTH + 1
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth_ctrl_t      ctrl,
    output logic [PW-1:0]    pp
);
    logic [PW-1:0] ext;
    logic [PW-1:0] sel;

    assign ext = {mcand[WIDTH-1], mcand};

    genvar b;
    generate
        for (b = 0; b < PW; b++) begin : g_bit
            logic lower;
            if (b == 0) begin : g_lsb
                assign lower = 1'b0;
            end else begin : g_upper
                assign lower = ext[b-1];
            end
            // 2:1 mux, zero gate, conditional inverter: constant depth per bit
            assign sel[b] = ctrl.shift ? lower : ext[b];
            assign pp[b]  = (sel[b] & ~ctrl.zero) ^ ctrl.neg;
        end
    endgenerate

    // R1: a zeroed operand leaves nothing in the partial product
    always_comb begin
        if (ctrl.zero && !ctrl.neg) begin
            a_r1_zero_clears: assert (pp == '0);
        end
    end
endmodule

// File: rtl/booth_recode_cell.sv
module booth_recode_cell
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       grp,
    input  logic [WIDTH-1:0] mcand,
    output logic [WIDTH:0]   pp,
    output logic             pp_corr,
    output logic             dig_zero,
    output logic             dig_shift,
    output logic             dig_neg
);
    booth_ctrl_t ctrl;

    booth_digit_decode u_dec (
        .grp  (grp),
        .ctrl (ctrl)
    );

    booth_pp_select #(.WIDTH(WIDTH)) u_sel (
        .mcand (mcand),
        .ctrl  (ctrl),
        .pp    (pp)
    );

    assign pp_corr   = ctrl.neg;
    assign dig_zero  = ctrl.zero;
    assign dig_shift = ctrl.shift;
    assign dig_neg   = ctrl.neg;

    always_comb begin
        // R6: digit 0 slices never owe a +1
        if (grp == 3'b000 || grp == 3'b111) begin
            a_r6_no_neg_zero: assert (!pp_corr);
        end
        // R5: negated nonzero operand flips the sign bit
        if (pp_corr && mcand != '0) begin
            a_r5_neg_sign: assert (pp[WIDTH] == ~mcand[WIDTH-1]);
        end
        // R2: positive nonzero digit keeps the operand's sign
        if (!grp[2] && grp != 3'b000 && mcand != '0) begin
            a_r2_pos_sign: assert (pp[WIDTH] == mcand[WIDTH-1]);
        end
    end
endmodule

// File: tb/booth_recode_cell_test.sv
module booth_recode_cell_test;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [2:0]   grp;
    logic [W-1:0] mcand;
    logic [W:0]   pp;
    logic         pp_corr, dig_zero, dig_shift, dig_neg;

    booth_recode_cell #(.WIDTH(W)) uut (
        .grp(grp), .mcand(mcand), .pp(pp), .pp_corr(pp_corr),
        .dig_zero(dig_zero), .dig_shift(dig_shift), .dig_neg(dig_neg)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (grp=%b mcand=%0d)",
                     req, act, exp, grp, $signed(mcand));
        end
    endtask

    initial begin
        grp = 3'b000; mcand = '0;
        @(negedge clk); #1;
        // R1 reset-like idle state: zero slice, zero operand
        chk(pp == '0, "R1", int'(pp), 0);
        chk(pp_corr == 1'b0, "R1", int'(pp_corr), 0);
        for (int g = 0; g < 8; g++) begin
            for (int m = 0; m < (1 << W); m++) begin
                int digit, sm, mag, val, sum;
                logic [W:0] exp_pp;
                @(negedge clk);
                grp = g[2:0];
                mcand = m[W-1:0];
                #1; // R8: checked in the same cycle as the input change
                digit = -2 * g[2] + g[1] + g[0];
                sm  = int'($signed(m[W-1:0]));
                mag = (digit < 0) ? -digit : digit;
                val = mag * sm;
                exp_pp = (digit < 0) ? ~val[W:0] : val[W:0];
                case (digit)
                    0:  chk(pp == exp_pp && !pp_corr, "R1", int'(pp), int'(exp_pp));
                    1:  chk(pp == exp_pp && !pp_corr, "R2", int'(pp), int'(exp_pp));
                    2:  chk(pp == exp_pp && !pp_corr, "R3", int'(pp), int'(exp_pp));
                    -2: chk(pp == exp_pp && pp_corr,  "R4", int'(pp), int'(exp_pp));
                    default: chk(pp == exp_pp && pp_corr, "R5", int'(pp), int'(exp_pp));
                endcase
                sum = int'($signed(pp)) + int'(pp_corr);
                chk(sum == digit * sm, "R6", sum, digit * sm);
                chk(pp_corr == dig_neg, "R6", int'(pp_corr), int'(dig_neg));
                chk(dig_zero == (digit == 0) && dig_shift == (mag == 2) && dig_neg == (digit < 0),
                    "R7", int'({dig_zero, dig_shift, dig_neg}),
                    int'({digit == 0, mag == 2, digit < 0}));
            end
        end
        // R6 corner: -2 times most negative value reaches +256
        @(negedge clk);
        grp = 3'b100; mcand = {1'b1, {(W-1){1'b0}}};
        #1;
        chk(int'($signed(pp)) + int'(pp_corr) == (1 << W), "R6",
            int'($signed(pp)) + int'(pp_corr), 1 << W);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule